// File: doc/BRIEF.md
# Runahead Mode Sequencer with Register Checkpoint

This block decides when a core leaves normal execution to pre-execute instructions speculatively while a long-latency load is outstanding. It holds the working register file, a shadow copy of that file, and one poison bit per register. The poison bit marks a value that depends on the outstanding miss.

Entry into speculative mode happens when the oldest instruction in the window reports a long-latency miss. In that cycle the whole register file is copied into the shadow, and the destination register of the missing load is poisoned. While speculative, results still land in the working file so that later instructions can compute addresses from them. Each result carries the poison flags of its sources, and each read port reports whether the value it returns is fit for forming a prefetch address or resolving a branch. When the triggering miss returns, the shadow is copied back in one cycle, every poison bit is cleared, and normal mode resumes. Nothing that software can see survives from the speculative interval.

The result write port is valid/ready. A write is taken on a clock edge only when `wr_valid` and `wr_ready` are both high. The block lowers `wr_ready` only in the cycle in which it restores the shadow. A producer must then hold its write and offer it again, because a write offered in that cycle leaves no trace. The miss status, the return event, the read ports and the mode output are plain signals.

Top module: `rah_ctrl`

## Requirements
- R1: After reset the mode output is 0 (normal), every register reads 0 with its valid-for-use flag at 1, and `wr_ready` is 1.
- R2: In normal mode, a cycle with `head_valid` and `head_miss` both high makes `runahead` read 1 from the next cycle. From that cycle on, the register named by `head_dst` reads with its valid-for-use flag at 0.
- R3: The shadow copy captures the register file as it stands after any write accepted in the entry cycle. After exit, every register reads back exactly that captured value, whatever was written during the speculative interval.
- R4: A write accepted during speculative mode is visible on the read ports from the next cycle, with the written data.
- R5: During speculative mode, a write sets the destination's valid-for-use flag to 0 if any bit of `wr_src_inv` is 1. It sets the flag to 1 if all bits of `wr_src_inv` are 0, and this also clears poison left by an earlier write or by entry.
- R6: In speculative mode, `miss_return` high makes `runahead` read 0 from the next cycle. The restore completes in that same edge, and every valid-for-use flag reads 1 afterwards.
- R7: `miss_return` in normal mode has no effect: the mode stays 0 and register contents are unchanged.
- R8: A second long-latency miss at the window head during speculative mode has no effect. It neither poisons its destination nor re-captures the shadow, so exit still restores the first snapshot.
- R9: `wr_ready` is 0 exactly in the cycle in which speculative mode is left. A write offered in that cycle is not accepted and does not change any register.
- R10: `head_miss` without `head_valid` does not start speculative mode.
- R11: In normal mode, writes ignore `wr_src_inv`, and every register reads with its valid-for-use flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Oldest window slot holds an instruction |
| head_miss | input | 1 | That instruction is a load missing to memory |
| head_dst | input | AW | Destination register of the oldest instruction |
| miss_return | input | 1 | The miss that started speculation has returned its data |
| wr_valid | input | 1 | Result write offered |
| wr_ready | output | 1 | Result write can be accepted this cycle |
| wr_addr | input | AW | Destination register of the write |
| wr_data | input | DW | Result value |
| wr_src_inv | input | NSRC | Poison flags of the producing instruction's sources |
| rd_addr | input | NRD x AW | Read port register indices |
| rd_data | output | NRD x DW | Read port values |
| rd_ok | output | NRD | Read value may be used for addresses and branches |
| runahead | output | 1 | 1 while in speculative mode |

## Verification
The result path is driven with writes whose source flags are all clear, a single flag set, and both flags set. This separates an OR of the sources from an AND or a single-bit tap, and the clean write shows that poison can be cleared as well as set. Mode changes are driven with a miss that lacks `head_valid`, a return that arrives while normal, a second miss during speculation, and a write offered in the exit cycle. These show that each trigger is qualified by both mode and validity. The snapshot is tested with a write in the entry cycle and overwrites during speculation. A restore that took the pre-write file or missed the overwrites would then read back a different value.

// File: rtl/rah_pkg.sv
package rah_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_AHEAD  = 1'b1
  } rah_mode_e;
endpackage

// File: rtl/rah_mode_fsm.sv
module rah_mode_fsm
  import rah_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  logic head_miss,
  input  logic miss_return,
  output logic ahead,
  output logic enter,
  output logic leave
);
  rah_mode_e mode_q;

  assign enter = (mode_q == MODE_NORMAL) && head_valid && head_miss;
  assign leave = (mode_q == MODE_AHEAD) && miss_return;
  assign ahead = (mode_q == MODE_AHEAD);

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= MODE_NORMAL;
    else if (enter) mode_q <= MODE_AHEAD;
    else if (leave) mode_q <= MODE_NORMAL;
  end

  // R2
  enter_goes_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ahead && head_valid && head_miss) |=> ahead);
  // R6
  return_goes_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ahead && miss_return) |=> !ahead);
  // R7
  idle_return_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ahead && !head_valid && miss_return) |=> !ahead);
  // R10
  unqualified_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ahead && !head_valid) |=> !ahead);
endmodule

// File: rtl/rah_inv_track.sv
module rah_inv_track #(
  parameter int NREG = 16,
  parameter int NSRC = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ahead,
  input  logic            enter,
  input  logic            leave,
  input  logic [AW-1:0]   head_dst,
  input  logic            wr_fire,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NSRC-1:0] wr_src_inv,
  output logic [NREG-1:0] inv
);
  logic src_any;
  assign src_any = |wr_src_inv;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic hit_wr, hit_head;
    assign hit_wr   = wr_fire && (wr_addr == AW'(i));
    assign hit_head = head_dst == AW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                 inv[i] <= 1'b0;
      else if (leave)             inv[i] <= 1'b0;
      else if (ahead && hit_wr)   inv[i] <= src_any;
      else if (enter && hit_head) inv[i] <= 1'b1;
    end
  end

  // R6
  clear_on_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (inv == '0));
  // R11
  normal_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ahead |-> (inv == '0));
  // R2
  head_poisoned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (inv != '0));
endmodule

// File: rtl/rah_regfile_ckpt.sv
module rah_regfile_ckpt #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ahead,
  input  logic                     enter,
  input  logic                     leave,
  input  logic                     wr_fire,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][DW-1:0]   rd_data
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] shadow_q;
  logic [NREG-1:0][DW-1:0] regs_nx;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    assign regs_nx[i] = (wr_fire && (wr_addr == AW'(i))) ? wr_data : regs_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n)     regs_q[i] <= '0;
      else if (leave) regs_q[i] <= shadow_q[i];
      else            regs_q[i] <= regs_nx[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     shadow_q[i] <= '0;
      else if (enter) shadow_q[i] <= regs_nx[i];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = regs_q[rd_addr[p]];
  end

  // R8
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ahead |=> $stable(shadow_q));
  // R3
  restore_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (regs_q == $past(shadow_q)));
endmodule

// File: rtl/rah_ctrl.sv
module rah_ctrl #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  parameter int NSRC = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   head_valid,
  input  logic                   head_miss,
  input  logic [AW-1:0]          head_dst,
  input  logic                   miss_return,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NSRC-1:0]        wr_src_inv,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data,
  output logic [NRD-1:0]         rd_ok,
  output logic                   runahead
);
  logic ahead, enter, leave, wr_fire;
  logic [NREG-1:0] inv;

  rah_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_miss(head_miss),
    .miss_return(miss_return), .ahead(ahead), .enter(enter), .leave(leave)
  );

  assign wr_ready = !leave;
  assign wr_fire  = wr_valid && wr_ready;
  assign runahead = ahead;

  rah_inv_track #(.NREG(NREG), .NSRC(NSRC), .AW(AW)) u_inv (
    .clk(clk), .rst_n(rst_n), .ahead(ahead), .enter(enter), .leave(leave),
    .head_dst(head_dst), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_src_inv(wr_src_inv), .inv(inv)
  );

  rah_regfile_ckpt #(.NREG(NREG), .DW(DW), .NRD(NRD), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ahead(ahead), .enter(enter), .leave(leave),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_ok
    assign rd_ok[p] = !inv[rd_addr[p]];
  end

  // R9
  ready_low_only_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (runahead && miss_return));
  // R4
  spec_write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runahead && !miss_return && wr_valid && rd_addr[0] == wr_addr) |=>
      (!runahead || $past(rd_addr[0]) != rd_addr[0] || rd_data[0] == $past(wr_data)));
endmodule

// File: tb/rah_ctrl_tb_top.sv
`timescale 1ns/1ps
module rah_ctrl_tb_top;
  localparam int NREG = 16, DW = 32, NRD = 2, NSRC = 2, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_valid = 0, head_miss = 0, miss_return = 0, wr_valid = 0;
  logic [AW-1:0] head_dst = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NSRC-1:0] wr_src_inv = '0;
  logic [NRD-1:0][AW-1:0] rd_addr = '0;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [NRD-1:0] rd_ok;
  logic wr_ready, runahead;

  always #4 clk = ~clk;

  rah_ctrl #(.NREG(NREG), .DW(DW), .NRD(NRD), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_miss(head_miss),
    .head_dst(head_dst), .miss_return(miss_return), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_src_inv(wr_src_inv), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ok(rd_ok), .runahead(runahead)
  );

  typedef struct {
    int kind;              // 0 register read, 1 mode, 2 ready
    logic [DW-1:0] data;
    logic ok;
    int req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops what the driver pushed at this negedge and compares
  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      case (e.kind)
        0: if (rd_data[0] !== e.data || rd_ok[0] !== e.ok) begin
             errors++;
             $display("FAIL R%0d read got %h/%0b expected %h/%0b", e.req, rd_data[0], rd_ok[0], e.data, e.ok);
           end
        1: if (runahead !== e.ok) begin
             errors++;
             $display("FAIL R%0d mode got %0b expected %0b", e.req, runahead, e.ok);
           end
        default: if (wr_ready !== e.ok) begin
             errors++;
             $display("FAIL R%0d ready got %0b expected %0b", e.req, wr_ready, e.ok);
           end
      endcase
    end
  end

  task automatic exp_reg(input int a, input logic [DW-1:0] d, input logic ok, input int req);
    exp_t e;
    @(negedge clk);
    rd_addr[0] = AW'(a);
    e.kind = 0; e.data = d; e.ok = ok; e.req = req;
    q.push_back(e);
  endtask

  task automatic exp_flag(input int kind, input logic v, input int req);
    exp_t e;
    @(negedge clk);
    e.kind = kind; e.data = '0; e.ok = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_all();
    head_valid = 0; head_miss = 0; miss_return = 0; wr_valid = 0; wr_src_inv = '0;
  endtask

  task automatic put(input int a, input logic [DW-1:0] d, input logic [NSRC-1:0] s);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d; wr_src_inv = s;
    @(negedge clk);
    idle_all();
  endtask

  task automatic pulse(input logic hv, input logic hm, input int dst, input logic ret);
    @(negedge clk);
    head_valid = hv; head_miss = hm; head_dst = AW'(dst); miss_return = ret;
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    exp_flag(1, 1'b0, 1);
    exp_flag(2, 1'b1, 1);
    exp_reg(3, 32'h0, 1'b1, 1);
    // R11 normal writes ignore source poison
    put(1, 32'h11, 2'b00);
    put(2, 32'h22, 2'b00);
    put(5, 32'h55, 2'b11);
    exp_reg(5, 32'h55, 1'b1, 11);
    // R7 stray return while normal
    pulse(0, 0, 0, 1);
    exp_flag(1, 1'b0, 7);
    exp_reg(1, 32'h11, 1'b1, 7);
    // R10 miss without valid
    pulse(0, 1, 4, 0);
    exp_flag(1, 1'b0, 10);
    exp_reg(4, 32'h0, 1'b1, 10);
    // R2 entry with a write in the same cycle (R3 snapshot must include it)
    @(negedge clk);
    head_valid = 1; head_miss = 1; head_dst = 4'd4;
    wr_valid = 1; wr_addr = 4'd2; wr_data = 32'h2A; wr_src_inv = '0;
    @(negedge clk);
    idle_all();
    exp_flag(1, 1'b1, 2);
    exp_reg(4, 32'h0, 1'b0, 2);
    exp_reg(2, 32'h2A, 1'b1, 3);
    // R4 speculative write visible
    put(1, 32'h99, 2'b00);
    exp_reg(1, 32'h99, 1'b1, 4);
    // R5 poison from one source, from the other, and clearing
    put(6, 32'h66, 2'b01);
    exp_reg(6, 32'h66, 1'b0, 5);
    put(7, 32'h77, 2'b10);
    exp_reg(7, 32'h77, 1'b0, 5);
    put(4, 32'h44, 2'b00);
    exp_reg(4, 32'h44, 1'b1, 5);
    // R8 second miss during speculation
    pulse(1, 1, 8, 0);
    exp_reg(8, 32'h0, 1'b1, 8);
    exp_flag(1, 1'b1, 8);
    put(2, 32'hBAD, 2'b00);
    // R9 exit cycle with an offered write
    @(negedge clk);
    miss_return = 1; wr_valid = 1; wr_addr = 4'd3; wr_data = 32'h33; wr_src_inv = '0;
    e.kind = 2; e.data = '0; e.ok = 1'b0; e.req = 9;
    q.push_back(e);
    @(negedge clk);
    idle_all();
    // R6 back to normal, poison cleared
    exp_flag(1, 1'b0, 6);
    exp_flag(2, 1'b1, 6);
    exp_reg(6, 32'h0, 1'b1, 6);
    exp_reg(7, 32'h0, 1'b1, 6);
    // R3 restored snapshot
    exp_reg(1, 32'h11, 1'b1, 3);
    exp_reg(2, 32'h2A, 1'b1, 3);
    exp_reg(4, 32'h0, 1'b1, 3);
    exp_reg(5, 32'h55, 1'b1, 3);
    // R9 dropped write left no trace
    exp_reg(3, 32'h0, 1'b1, 9);
    // R9 write accepted once offered again
    put(3, 32'h33, 2'b00);
    exp_reg(3, 32'h33, 1'b1, 9);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule